// File: doc/BRIEF.md
# Synchronizable Clock Divider with Phase Offset

The block turns a fast input clock into a one-cycle-wide sampling enable that fires once every N input cycles, with N picked from 1, 2, 4 and 8. An external SYNC input, already synchronous to the clock, returns the divider to a known state. When every device on a board receives the same SYNC pulse, their divided enables line up. After each realignment a programmable offset, counted in input clock cycles, shifts where the enable lands.

Software writes a control register that holds the divide select and a two-bit SYNC mode. A second register holds the phase offset. In one mode the block realigns on every SYNC edge. In another it realigns only on the first edge after the control register was last written, and a status flag shows that this one-shot realignment is still pending.

The realignment policy lives in a small state machine with four states:
- **ST_FREE**: SYNC is ignored.
- **ST_TRACK**: every SYNC edge is honored.
- **ST_ARMED**: waiting for the one qualifying edge.
- **ST_SPENT**: the qualifying edge has been used.

A control write moves the machine into the state named by the written mode: FREE for off, TRACK for every-edge, ARMED for first-only. The only other transition is ARMED→SPENT on an honored SYNC edge without a write. A phase counter produces the enable.

Top module: `clkdiv_sync_top`

## Requirements
- R1: After reset, the divide ratio is 1, SYNC mode is off, `sync_armed` is 0 and `div_en` is 1 on every cycle.
- R2: `ctrl_ratio` codes 0, 1, 2 and 3 select a ratio N of 1, 2, 4 and 8. When no realignment occurs, `div_en` is high for exactly one cycle in every N.
- R3: A new ratio takes effect at the next counter wrap or the next honored SYNC, whichever comes first. The period that is running when the write happens is completed at the old length.
- R4: A SYNC event is a cycle in which `sync_in` is 1 and was 0 in the previous cycle. Holding `sync_in` high does not produce further events.
- R5: `ctrl_mode` code 0 makes SYNC events have no effect, code 1 honors every SYNC event, and codes 2 and 3 honor only the first event after the write.
- R6: With phase 0, an honored SYNC sampled at clock edge E makes `div_en` high in the cycle right after E and every N cycles after that.
- R7: Writing `ctrl_mode` code 2 or 3 raises `sync_armed` on the next cycle. The first SYNC event after that is honored and clears `sync_armed`. Later events are ignored until the control register is written again.
- R8: For a phase value p, the counter restarts at p mod N after an honored SYNC. The first `div_en` then comes 1 + ((N − p mod N) mod N) cycles after the sampling edge.
- R9: With N = 1, `div_en` stays 1 on every cycle, whatever the SYNC activity or phase value.
- R10: When a control write and a SYNC event fall in the same cycle:
  - The event is judged by the mode in force before the write.
  - An honored event uses the ratio and phase being written in that cycle.
  - The state afterwards follows the written mode, so a first-only write leaves `sync_armed` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_ratio | input | RATIO_SEL_W | Divide select code, where N = 2^code |
| ctrl_mode | input | 2 | SYNC mode: 0 off, 1 every edge, 2 or 3 first edge only |
| phase_we | input | 1 | Write strobe for the phase register |
| phase_val | input | PHASE_W | Post-sync phase offset in input cycles |
| sync_in | input | 1 | Synchronous SYNC request |
| div_en | output | 1 | Divided clock enable, one cycle wide |
| sync_armed | output | 1 | High while a first-only realignment is pending |

## Verification
A register write and a SYNC edge can land on the same clock edge. Both then try to decide the divider's mode, its ratio and its phase at once. The bench provokes this while the machine is armed at ratio 8. In the same cycle as the SYNC edge, it writes ratio 4 with phase 0 and first-only mode. It then expects an enable on the very next cycle, a period of 4 from then on, and `sync_armed` still high. Each of these three outcomes shows a different half of the ordering rule: the edge judged by the old mode, the realignment using the new values, and the state following the new mode.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

    // Realignment policy states
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_ARMED = 2'd2,
        ST_SPENT = 2'd3
    } sync_state_e;

    // Mode field codes
    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_EVERY = 2'b01;

    // State a control write selects
    function automatic sync_state_e state_for_mode(input logic [1:0] mode);
        sync_state_e s;
        if (mode[1])
            s = ST_ARMED;
        else if (mode == MODE_EVERY)
            s = ST_TRACK;
        else
            s = ST_FREE;
        return s;
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
    parameter int SEL_W = 2,
    parameter int PH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             phase_we,
    input  logic [PH_W-1:0]  wr_phase,
    output logic [SEL_W-1:0] sel_eff,
    output logic [PH_W-1:0]  phase_eff
);

    logic [SEL_W-1:0] sel_q;
    logic [PH_W-1:0]  phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            phase_q <= '0;
        end else begin
            if (ctrl_we)
                sel_q <= wr_sel;
            if (phase_we)
                phase_q <= wr_phase;
        end
    end

    // A write in flight is visible to a same-cycle wrap or realignment
    always_comb begin
        sel_eff   = ctrl_we  ? wr_sel   : sel_q;
        phase_eff = phase_we ? wr_phase : phase_q;
    end

endmodule

// File: rtl/clkdiv_sync_fsm.sv
module clkdiv_sync_fsm
    import clkdiv_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       ctrl_we,
    input  logic [1:0] wr_mode,
    output logic       honored,
    output logic       armed
);

    sync_state_e state_q, state_d;
    logic        sync_prev;
    logic        edge_seen;

    // Previous SYNC level, kept during reset so a held level never looks new
    always_ff @(posedge clk) begin
        sync_prev <= sync_in;
    end

    assign edge_seen = sync_in & ~sync_prev;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_FREE;
        else
            state_q <= state_d;
    end

    // Next state: a control write overrides every other transition
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = state_for_mode(wr_mode);
        end else begin
            unique case (state_q)
                ST_FREE:  state_d = ST_FREE;
                ST_TRACK: state_d = ST_TRACK;
                ST_ARMED: state_d = edge_seen ? ST_SPENT : ST_ARMED;
                ST_SPENT: state_d = ST_SPENT;
            endcase
        end
    end

    // Outputs: the edge is judged by the state held before any write
    always_comb begin
        honored = 1'b0;
        armed   = 1'b0;
        unique case (state_q)
            ST_FREE:  honored = 1'b0;
            ST_TRACK: honored = edge_seen;
            ST_ARMED: begin
                honored = edge_seen;
                armed   = 1'b1;
            end
            ST_SPENT: honored = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
    parameter int SEL_W = 2,
    parameter int PH_W  = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             honored,
    input  logic [SEL_W-1:0] sel_eff,
    input  logic [PH_W-1:0]  phase_eff,
    output logic             div_en,
    output logic [SEL_W-1:0] act_sel
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] new_mask;
    logic [CNT_W-1:0] phase_ext;
    logic             wrap;

    always_comb begin
        last_cnt = CNT_W'((1 << act_sel) - 1);
        new_mask = CNT_W'((1 << sel_eff) - 1);
        if (PH_W >= CNT_W)
            phase_ext = CNT_W'(phase_eff);
        else
            phase_ext = CNT_W'({{CNT_W{1'b0}}, phase_eff});
        wrap = (cnt_q == last_cnt);
    end

    // Ratio changes only at a wrap or an honored realignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_sel <= '0;
        end else if (honored) begin
            act_sel <= sel_eff;
            cnt_q   <= phase_ext & new_mask;
        end else if (wrap) begin
            act_sel <= sel_eff;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_en = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_sync_top.sv
module clkdiv_sync_top #(
    parameter int RATIO_SEL_W = 2,
    parameter int PHASE_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_we,
    input  logic [RATIO_SEL_W-1:0] ctrl_ratio,
    input  logic [1:0]             ctrl_mode,
    input  logic                   phase_we,
    input  logic [PHASE_W-1:0]     phase_val,
    input  logic                   sync_in,
    output logic                   div_en,
    output logic                   sync_armed
);

    localparam int CNT_W = (2 ** RATIO_SEL_W) - 1;

    logic [RATIO_SEL_W-1:0] sel_eff;
    logic [PHASE_W-1:0]     phase_eff;
    logic [RATIO_SEL_W-1:0] act_sel;
    logic                   sync_hit;

    clkdiv_cfg #(
        .SEL_W (RATIO_SEL_W),
        .PH_W  (PHASE_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .wr_sel    (ctrl_ratio),
        .phase_we  (phase_we),
        .wr_phase  (phase_val),
        .sel_eff   (sel_eff),
        .phase_eff (phase_eff)
    );

    clkdiv_sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .ctrl_we (ctrl_we),
        .wr_mode (ctrl_mode),
        .honored (sync_hit),
        .armed   (sync_armed)
    );

    clkdiv_phase_cnt #(
        .SEL_W (RATIO_SEL_W),
        .PH_W  (PHASE_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .honored   (sync_hit),
        .sel_eff   (sel_eff),
        .phase_eff (phase_eff),
        .div_en    (div_en),
        .act_sel   (act_sel)
    );

endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             ctrl_we,
    input logic [1:0]       wr_mode,
    input logic             div_en,
    input logic             armed,
    input logic             honored,
    input logic [SEL_W-1:0] act_sel
);

    assert_ratio1_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel == '0) |-> div_en);

    assert_no_runt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && act_sel != '0 && !honored) |=> !div_en);

    assert_arm_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_mode[1]) |=> armed);

    assert_off_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wr_mode[1]) |=> !armed);

    assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && honored && !ctrl_we) |=> !armed);

    assert_level_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && $past(sync_in)) |-> !honored);

    assert_realign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (honored && !armed && !ctrl_we && wr_mode == 2'b00) |-> sync_in);

endmodule

bind clkdiv_sync_top clkdiv_sync_chk #(.SEL_W(RATIO_SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .ctrl_we (ctrl_we),
    .wr_mode (ctrl_mode),
    .div_en  (div_en),
    .armed   (sync_armed),
    .honored (sync_hit),
    .act_sel (act_sel)
);

// File: tb/clkdiv_sync_top_tb.sv
module clkdiv_sync_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {ratio code, phase, cycles to first enable, period}
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{1, 0, 1, 2}, '{1, 1, 2, 2}, '{2, 0, 1, 4}, '{2, 3, 2, 4},
        '{2, 5, 4, 4}, '{3, 0, 1, 8}, '{3, 3, 6, 8}, '{3, 7, 2, 8},
        '{0, 5, 1, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [1:0] ctrl_ratio = '0;
    logic [1:0] ctrl_mode = '0;
    logic       phase_we = 1'b0;
    logic [2:0] phase_val = '0;
    logic       sync_in = 1'b0;
    logic       div_en;
    logic       sync_armed;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_sync_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_ratio (ctrl_ratio),
        .ctrl_mode  (ctrl_mode),
        .phase_we   (phase_we),
        .phase_val  (phase_val),
        .sync_in    (sync_in),
        .div_en     (div_en),
        .sync_armed (sync_armed)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input int sel, input int mode);
        ctrl_we = 1'b1;
        ctrl_ratio = 2'(sel);
        ctrl_mode = 2'(mode);
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_phase(input int p);
        phase_we = 1'b1;
        phase_val = 3'(p);
        @(negedge clk);
        phase_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic to_next_en(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_en && k < 64);
    endtask

    // Raise SYNC at this negedge; k counts cycles after the sampling edge
    task automatic sync_measure(input bit hold, output int k, output int per);
        sync_in = 1'b1;
        @(negedge clk);
        k = 1;
        if (!hold) sync_in = 1'b0;
        while (!div_en && k < 64) begin
            @(negedge clk);
            k++;
        end
        to_next_en(per);
        sync_in = 1'b0;
    endtask

    // Called at a negedge where div_en=1 and N=4: an edge now must change nothing
    task automatic sync_ignored(input string req);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        check(div_en == 1'b0, req, int'(div_en), 0);
        idle(3);
        check(div_en == 1'b1, req, int'(div_en), 1);
    endtask

    initial begin
        int k, per, lows;
        // R1: reset state
        idle(2);
        check(div_en == 1'b1, "R1 div_en in reset", int'(div_en), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!div_en) lows++;
        end
        check(lows == 0, "R1 ratio 1 after reset", lows, 0);
        check(sync_armed == 1'b0, "R1 armed after reset", int'(sync_armed), 0);

        // Table: R2 periods, R6 realign, R8 phase offset, R9 ratio 1
        for (int v = 0; v < NVEC; v++) begin
            wr_ctrl(VEC[v][0], 1);
            wr_phase(VEC[v][1]);
            idle(20);
            sync_measure(1'b0, k, per);
            check(k == VEC[v][2], "R8 first enable after SYNC", k, VEC[v][2]);
            check(per == VEC[v][3], "R2 period after SYNC", per, VEC[v][3]);
        end

        // R9: ratio 1 with SYNC toggling and nonzero phase
        wr_ctrl(0, 1);
        wr_phase(5);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            sync_in = i[0];
            @(negedge clk);
            if (!div_en) lows++;
        end
        sync_in = 1'b0;
        check(lows == 0, "R9 ratio 1 constant enable", lows, 0);

        // R5: mode off ignores SYNC
        wr_ctrl(2, 0);
        wr_phase(0);
        idle(10);
        to_next_en(k);
        sync_ignored("R5 mode off");

        // R4: SYNC held high realigns only once
        wr_ctrl(2, 1);
        idle(10);
        sync_measure(1'b1, k, per);
        check(k == 1, "R4 held SYNC first enable", k, 1);
        check(per == 4, "R4 held SYNC period", per, 4);

        // R7: first-only mode
        wr_ctrl(2, 2);
        check(sync_armed == 1'b1, "R7 armed after write", int'(sync_armed), 1);
        idle(9);
        sync_measure(1'b0, k, per);
        check(k == 1, "R7 first SYNC honored", k, 1);
        check(sync_armed == 1'b0, "R7 armed cleared", int'(sync_armed), 0);
        sync_ignored("R7 later SYNC ignored");
        check(sync_armed == 1'b0, "R7 stays clear", int'(sync_armed), 0);

        // R3: ratio change waits for wrap
        wr_ctrl(3, 0);
        idle(20);
        to_next_en(k);
        @(negedge clk);
        wr_ctrl(1, 0);
        to_next_en(k);
        check(k == 6, "R3 running period completed", k, 6);
        to_next_en(per);
        check(per == 2, "R3 new period", per, 2);

        // R10: write and SYNC edge in the same cycle
        wr_ctrl(3, 2);
        idle(20);
        ctrl_we = 1'b1;
        ctrl_ratio = 2'd2;
        ctrl_mode = 2'd2;
        phase_we = 1'b1;
        phase_val = 3'd0;
        sync_in = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        phase_we = 1'b0;
        sync_in = 1'b0;
        check(div_en == 1'b1, "R10 realigned by old mode", int'(div_en), 1);
        check(sync_armed == 1'b1, "R10 re-armed by write", int'(sync_armed), 1);
        to_next_en(per);
        check(per == 4, "R10 written ratio used", per, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule